// File: doc/BRIEF.md
# Lane-Segmented Wide Unsigned Adder

This block adds two wide unsigned operands with nothing wider than a lane-sized adder. The operands are cut into equal lanes, 64 bits each by default, and every lane is summed on its own. A lane overflows when one summand is larger than the headroom left by the other, where headroom means the all-ones lane value minus that summand. That comparison runs in every lane at once and gives one carry bit per lane. The carry vector is then moved up exactly one lane and added in a second, registered pass. A carry never ripples across the whole width.

The lane count sets the width. Two, four and eight lanes give 128, 256 and 512 bits. When the B operand stays the same across many additions, the caller drives it once with the constant flag low. The block keeps that value and its headroom. While the flag is high, the block uses the kept copy and ignores the B pins.

The second pass does not pass on a carry that it creates itself. This happens when a lane's first-pass sum is all ones and a carry arrives from below. That lane then wraps to zero and the carry is lost. The block raises an error output for that result so the caller can detect it.

Top module: `lane_split_adder`

## Requirements
- R1: Lane 0 of the sum equals (A lane 0 + B lane 0) modulo 2^64, because lane 0 never receives a carry.
- R2: When `wrap_err` is low, `sum_out` equals (A + B) modulo 2^W for the full width W, where lane i occupies bits [64i+63:64i].
- R3: `carry_out` equals the first-pass carry of the top lane, that is, whether the top lanes of A and B sum to 2^64 or more. This carry is left out of `sum_out`.
- R4: `wrap_err` is high exactly when some lane i ≥ 1 has a first-pass sum of all ones and lane i−1 overflowed in the first pass. That lane of `sum_out` is then zero, and no further carry is applied.
- R5: The result of the operands presented at a rising edge appears on the outputs after the second rising edge. A new operand pair is accepted every cycle.
- R6: While `b_const` is high, `b_in` has no effect. The block uses the B value present at the last rising edge where `b_const` was low.
- R7: While reset is active, `sum_out`, `carry_out` and `wrap_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B; it is captured as the kept constant while `b_const` is low |
| b_const | input | 1 | High: use the kept B and its precomputed headroom |
| sum_out | output | W | Lane-wise sum, two cycles after the operands |
| carry_out | output | 1 | First-pass carry out of the top lane |
| wrap_err | output | 1 | A second-pass carry was lost |

## Verification
The assertions that compare lane 0 and the top-lane carry against earlier inputs apply only when `b_const` was low two cycles before. Only then do the B pins carry the operand actually used. The assertions also assume at least two clocks have passed since reset, so that a history exists to compare against.

The bench keeps to these conditions. It stays in direct-operand mode for those comparisons and checks constant mode through the outputs instead. It builds lanes from random, all-ones and zero patterns, which reaches lost-carry cases often, and it checks the full-width sum only when no carry was lost.

// File: rtl/lane_split_adder.sv
module lane_split_adder #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4,
  localparam int W     = LANE_W * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         b_const,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         wrap_err
);

  logic [W-1:0] bk_q, room_q;
  logic [W-1:0] b_sel, room_sel;
  logic [W-1:0] psum, ps_q, sum_d;
  logic [LANES-1:0] cmask, cm_q, cin, wrap;

  assign b_sel    = b_const ? bk_q   : b_in;
  assign room_sel = b_const ? room_q : ~b_in;
  assign cin      = {cm_q[LANES-2:0], 1'b0};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, r_l, p_l;
    assign a_l = a_in[i*LANE_W +: LANE_W];
    assign b_l = b_sel[i*LANE_W +: LANE_W];
    assign r_l = room_sel[i*LANE_W +: LANE_W];
    assign psum[i*LANE_W +: LANE_W] = a_l + b_l;
    assign cmask[i] = a_l > r_l;
    assign p_l = ps_q[i*LANE_W +: LANE_W];
    assign sum_d[i*LANE_W +: LANE_W] = p_l + {{(LANE_W-1){1'b0}}, cin[i]};
    assign wrap[i] = cin[i] & (&p_l);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_q      <= '0;
      room_q    <= '1;
      ps_q      <= '0;
      cm_q      <= '0;
      sum_out   <= '0;
      carry_out <= 1'b0;
      wrap_err  <= 1'b0;
    end else begin
      if (!b_const) begin
        bk_q   <= b_in;
        room_q <= ~b_in;
      end
      ps_q      <= psum;
      cm_q      <= cmask;
      sum_out   <= sum_d;
      carry_out <= cm_q[LANES-1];
      wrap_err  <= |wrap;
    end
  end

endmodule

// File: rtl/lane_split_adder_chk.sv
module lane_split_adder_chk #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4,
  localparam int W     = LANE_W * LANES
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         b_const,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic         wrap_err,
  input logic [W-1:0] bk_q
);

  logic [1:0] warm;
  logic [LANE_W:0] top_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assign top_sum = {1'b0, a_in[W-1 -: LANE_W]} + {1'b0, b_in[W-1 -: LANE_W]};

  function automatic logic upper_zero(input logic [W-1:0] s);
    logic z = 1'b0;
    for (int i = 1; i < LANES; i++)
      if (s[i*LANE_W +: LANE_W] == '0) z = 1'b1;
    return z;
  endfunction

  assert_lane0_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(!b_const, 2)) |->
      sum_out[LANE_W-1:0] == LANE_W'($past(a_in[LANE_W-1:0], 2) + $past(b_in[LANE_W-1:0], 2)));

  assert_top_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && $past(!b_const, 2)) |-> carry_out == $past(top_sum[LANE_W], 2));

  assert_const_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && b_const && $past(b_const)) |-> $stable(bk_q));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_err |-> upper_zero(sum_out));

endmodule

bind lane_split_adder lane_split_adder_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .b_const(b_const),
  .sum_out(sum_out), .carry_out(carry_out), .wrap_err(wrap_err), .bk_q(bk_q)
);

// File: tb/lane_split_adder_tb.sv
module lane_split_adder_tb;
  localparam int LW = 64;
  localparam int NL = 4;
  localparam int W  = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic b_const = 1'b0;
  logic [W-1:0] sum_out;
  logic carry_out, wrap_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lane_split_adder #(.LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .b_const(b_const),
    .sum_out(sum_out), .carry_out(carry_out), .wrap_err(wrap_err));

  function automatic logic [W-1:0] rand_lanes();
    logic [W-1:0] v;
    for (int i = 0; i < NL; i++) begin
      case ($urandom % 4)
        0: v[i*LW +: LW] = '1;
        1: v[i*LW +: LW] = '0;
        default: v[i*LW +: LW] = {$urandom, $urandom};
      endcase
    end
    return v;
  endfunction

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] s, output logic cy, output logic er);
    logic [LW:0] t;
    logic [NL-1:0] c;
    logic [LW-1:0] p [NL];
    for (int i = 0; i < NL; i++) begin
      t = {1'b0, a[i*LW +: LW]} + {1'b0, b[i*LW +: LW]};
      p[i] = t[LW-1:0];
      c[i] = t[LW];
    end
    er = 1'b0;
    s[LW-1:0] = p[0];
    for (int i = 1; i < NL; i++) begin
      if (c[i-1] && p[i] == '1) er = 1'b1;
      s[i*LW +: LW] = p[i] + LW'(c[i-1]);
    end
    cy = c[NL-1];
  endtask

  task automatic check(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] es;
    logic ec, ee;
    model(a, b, es, ec, ee);
    checks++;
    if (sum_out !== es || carry_out !== ec || wrap_err !== ee) begin
      errors++;
      $display("FAIL %s sum=%h cy=%b err=%b expected sum=%h cy=%b err=%b",
               req, sum_out, carry_out, wrap_err, es, ec, ee);
    end
    if (!ee) begin
      checks++;
      if (sum_out !== W'(a + b)) begin
        errors++;
        $display("FAIL R2 sum=%h expected %h", sum_out, W'(a + b));
      end
    end
  endtask

  task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    a_in = a; b_in = b; b_const = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req, a, b);
  endtask

  initial begin
    #(5.0 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ka, kb, ra;
    void'($urandom(32'd7071));
    repeat (3) @(negedge clk);
    checks++;
    if (sum_out !== '0 || carry_out !== 1'b0 || wrap_err !== 1'b0) begin
      errors++;
      $display("FAIL R7 sum=%h cy=%b err=%b expected 0 0 0", sum_out, carry_out, wrap_err);
    end
    rst_n = 1'b1;

    run("R1", W'(64'hFFFF_FFFF_FFFF_FFFF), W'(1));
    run("R4", '1, W'(1));
    run("R3", {64'hFFFF_FFFF_FFFF_FFFF, {(W-LW){1'b0}}}, {64'h1, {(W-LW){1'b0}}});
    run("R2", '0, '0);
    run("R2", {64'h0, 64'h5, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, W'(1));

    for (int n = 0; n < 300; n++) begin
      ka = (n % 2 == 0) ? rand_lanes() : {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      kb = rand_lanes();
      run("R1 R3 R4", ka, kb);
    end

    // R5: back-to-back operands, each result two edges later
    @(negedge clk);
    a_in = W'(64'h10); b_in = W'(64'h20);
    @(negedge clk);
    a_in = '1; b_in = W'(1);
    @(negedge clk);
    check("R5", W'(64'h10), W'(64'h20));
    @(negedge clk);
    check("R5", '1, W'(1));

    // R6: kept constant, b_in ignored while b_const high
    for (int n = 0; n < 40; n++) begin
      kb = rand_lanes();
      @(negedge clk);
      b_const = 1'b0; b_in = kb;
      for (int m = 0; m < 3; m++) begin
        ra = rand_lanes();
        @(negedge clk);
        b_const = 1'b1; a_in = ra; b_in = rand_lanes();
        @(negedge clk);
        @(negedge clk);
        check("R6", ra, kb);
      end
    end
    b_const = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule